// File: doc/BRIEF.md
# Flag-Terminated Serial Decimal Adder

This block adds two decimal numbers of variable length that live in a digit memory outside the block. Each memory cell holds one BCD digit together with an end marker and one spare bit. The caller supplies the addresses of the lowest-order digit of each operand and pulses `start`. The block then walks both fields one digit at a time toward the high-order end, and high order sits at lower addresses. It writes each decimal sum digit back over the first operand, A. It stops after the cell of A whose end marker is set.

No binary adder is used. Each sum digit and its carry are read from a lookup table indexed by the two digits and the incoming carry. If a carry is left over after the last digit, an overflow flag is raised. A stored digit outside 0 to 9 ends the operation early and raises an error flag.

The block reaches memory through a single synchronous port, and read data arrives one cycle after the address. A digit step always takes four cycles: fetch A, fetch B, look up, write.

Top module: `serial_dec_adder`

## Requirements
- R1: A memory cell is 6 bits wide. Bits [3:0] hold the BCD digit, bit 4 is the end marker, and bit 5 is a spare bit.
- R2: Digits are processed from low order to high order. After each digit, both the A address and the B address step down by one, modulo 2^ADDR_W.
- R3: Each result digit equals (a + b + carry_in) mod 10. The carry into the next digit is 1 when a + b + carry_in exceeds 9. The carry into the lowest digit is 0.
- R4: The length of the field is set only by the end marker of operand A. The end markers of operand B are ignored. No cell above A's marked digit is written.
- R5: A result cell keeps the end marker and the spare bit of the A cell it replaces. The spare bit of B has no effect.
- R6: When `start` is accepted, `done` rises as a single-cycle pulse exactly 4·N clock edges later for an N-digit field, one cycle after the marked digit has been written. `busy` is high from the edge after `start` until `done`.
- R7: `overflow` rises together with `done` when a carry leaves the marked digit. It stays at that value until the next accepted `start`, which clears it.
- R8: If a fetched A or B digit is greater than 9, that digit is not written. `digit_err` and `done` rise together 4·k−1 edges after `start`, where k is the 1-based position of the bad digit. `overflow` stays 0. Earlier digits keep their results.
- R9: A `start` pulse while `busy` is high is ignored.
- R10: While reset is held and after it is released, `busy`, `done`, `overflow`, `digit_err` and `mem_we` are 0.
- R11: `mem_we` is never high in two consecutive cycles, so each digit is written at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an addition when the block is idle |
| a_lo_addr | input | ADDR_W | Address of A's lowest-order digit; the result is written over A |
| b_lo_addr | input | ADDR_W | Address of B's lowest-order digit |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 6 | Cell written to memory |
| mem_rdata | input | 6 | Cell read from memory, one cycle after the address |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Carry left after the marked digit |
| digit_err | output | 1 | A non-BCD digit aborted the run |

## Verification
The bench builds the block with its default ADDR_W of 8, which gives a 256-cell address space. The operand fields are placed at separate addresses in the middle of that space, so the step toward lower addresses never wraps. Guard cells just above each field show that the walk ends at A's marker.

With this setting, fields of 1 to 8 digits are exercised. The runs include a carry that ripples through the whole field and an overflow out of the top digit. They also cover B markers placed early, spare bits that differ between A and B, and bad digits in either operand. A second `start` arriving in the middle of a run is also covered.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
  localparam int DIG_W  = 4;
  localparam int CELL_W = DIG_W + 2;
  localparam int LUT_IW = 2 * DIG_W + 1;

  // R1: bit 5 spare, bit 4 end marker, bits 3:0 BCD digit
  typedef struct packed {
    logic             spare;
    logic             fin;
    logic [DIG_W-1:0] val;
  } cell_t;
endpackage

// File: rtl/sdadd_sum_rom.sv
module sdadd_sum_rom
  import sdadd_pkg::*;
(
  input  logic             clk,
  input  logic             en,
  input  logic [DIG_W-1:0] dig_a,
  input  logic [DIG_W-1:0] dig_b,
  input  logic             cin,
  output logic [DIG_W-1:0] sum_q,
  output logic             cout_q
);
  localparam int ENTRIES = 1 << LUT_IW;

  logic [DIG_W:0] table_q [ENTRIES];

  // Table contents are fixed at elaboration; index is {cin, a, b}.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int DA  = (i >> DIG_W) & ((1 << DIG_W) - 1);
    localparam int DB  = i & ((1 << DIG_W) - 1);
    localparam int CI  = i >> (2 * DIG_W);
    localparam int TOT = DA + DB + CI;
    if (DA > 9 || DB > 9) begin : g_bad
      assign table_q[i] = '0;
    end else if (TOT > 9) begin : g_carry
      assign table_q[i] = {1'b1, DIG_W'(TOT - 10)};
    end else begin : g_plain
      assign table_q[i] = {1'b0, DIG_W'(TOT)};
    end
  end

  always_ff @(posedge clk) begin
    if (en) {cout_q, sum_q} <= table_q[{cin, dig_a, dig_b}];
  end
endmodule

// File: rtl/sdadd_walk_ctrl.sv
module sdadd_walk_ctrl
  import sdadd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] a_lo_addr,
  input  logic [ADDR_W-1:0] b_lo_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [CELL_W-1:0] mem_wdata,
  input  logic [CELL_W-1:0] mem_rdata,
  output logic              lut_en,
  output logic [DIG_W-1:0]  lut_a,
  output logic [DIG_W-1:0]  lut_b,
  output logic              lut_cin,
  input  logic [DIG_W-1:0]  lut_sum,
  input  logic              lut_cout,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic              digit_err
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH_A, S_FETCH_B, S_LOOK, S_PUT} step_t;

  step_t             st;
  logic [ADDR_W-1:0] a_ptr, b_ptr;
  logic              carry;
  cell_t             a_cell;
  logic [DIG_W-1:0]  b_val;
  logic              non_bcd;

  assign b_val   = mem_rdata[DIG_W-1:0];
  assign non_bcd = (a_cell.val > 4'd9) || (b_val > 4'd9);

  assign mem_addr  = (st == S_FETCH_B) ? b_ptr : a_ptr;
  assign mem_we    = (st == S_PUT);
  assign mem_wdata = {a_cell.spare, a_cell.fin, lut_sum};

  assign lut_en  = (st == S_LOOK);
  assign lut_a   = a_cell.val;
  assign lut_b   = b_val;
  assign lut_cin = carry;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      a_ptr     <= '0;
      b_ptr     <= '0;
      carry     <= 1'b0;
      a_cell    <= '0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      digit_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            a_ptr     <= a_lo_addr;
            b_ptr     <= b_lo_addr;
            carry     <= 1'b0;
            overflow  <= 1'b0;
            digit_err <= 1'b0;
            st        <= S_FETCH_A;
          end
        end
        S_FETCH_A: st <= S_FETCH_B;
        S_FETCH_B: begin
          a_cell <= cell_t'(mem_rdata);
          st     <= S_LOOK;
        end
        S_LOOK: begin
          if (non_bcd) begin
            digit_err <= 1'b1;
            done      <= 1'b1;
            st        <= S_IDLE;
          end else begin
            st <= S_PUT;
          end
        end
        S_PUT: begin
          carry <= lut_cout;
          if (a_cell.fin) begin
            overflow <= lut_cout;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            a_ptr <= a_ptr - 1'b1;
            b_ptr <= b_ptr - 1'b1;
            st    <= S_FETCH_A;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_wdata[DIG_W]) |=> (mem_addr == $past(mem_addr) - 1'b1));

  // R3
  bcd_result_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[DIG_W-1:0] <= 4'd9));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(digit_err) |-> (done && !overflow));
endmodule

// File: rtl/serial_dec_adder.sv
module serial_dec_adder
  import sdadd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] a_lo_addr,
  input  logic [ADDR_W-1:0] b_lo_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [CELL_W-1:0] mem_wdata,
  input  logic [CELL_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic              digit_err
);
  logic             lut_en;
  logic [DIG_W-1:0] lut_a, lut_b, lut_sum;
  logic             lut_cin, lut_cout;

  sdadd_walk_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .a_lo_addr (a_lo_addr),
    .b_lo_addr (b_lo_addr),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .lut_en    (lut_en),
    .lut_a     (lut_a),
    .lut_b     (lut_b),
    .lut_cin   (lut_cin),
    .lut_sum   (lut_sum),
    .lut_cout  (lut_cout),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow),
    .digit_err (digit_err)
  );

  sdadd_sum_rom rom_i (
    .clk    (clk),
    .en     (lut_en),
    .dig_a  (lut_a),
    .dig_b  (lut_b),
    .cin    (lut_cin),
    .sum_q  (lut_sum),
    .cout_q (lut_cout)
  );

  // R10
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> !mem_we);
endmodule

// File: tb/serial_dec_adder_tb_top.sv
module serial_dec_adder_tb_top;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_BASE = 8'hC0;
  localparam logic [AW-1:0] B_BASE = 8'h60;
  localparam logic [AW-1:0] STRAY  = 8'h20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] a_lo_addr = '0, b_lo_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [5:0]    mem_wdata, mem_rdata;
  logic          busy, done, overflow, digit_err;

  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [5:0]    tb_wdata = '0;
  logic [5:0]    mem [1 << AW];

  int vecs = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 4 ns period

  serial_dec_adder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .a_lo_addr(a_lo_addr), .b_lo_addr(b_lo_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .overflow(overflow), .digit_err(digit_err)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_addr] <= tb_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] addr, input logic [5:0] val);
    tb_addr = addr; tb_wdata = val; tb_we = 1'b1;
    @(posedge clk); #1;
    tb_we = 1'b0;
  endtask

  // bad_sel: 0 none, 1 bad digit in A, 2 bad digit in B, at index bad_at
  task automatic run_case(input string name, input int n, input logic [31:0] an, input logic [31:0] bn,
                          input int b_flag_at, input logic [7:0] a_sp, input int bad_sel, input int bad_at,
                          input bit poke_mid);
    logic [3:0] ad [8];
    logic [3:0] bd [8];
    logic [3:0] ed [8];
    int c, s, stop, cnt, lat;
    bit exp_ovf;
    for (int i = 0; i < 8; i++) begin
      ad[i] = an[4*i +: 4]; bd[i] = bn[4*i +: 4];
    end
    if (bad_sel == 1) ad[bad_at] = 4'hC;
    if (bad_sel == 2) bd[bad_at] = 4'hB;
    for (int i = 0; i < n; i++) begin
      poke(A_BASE - AW'(i), {a_sp[i], (i == n - 1), ad[i]});
      poke(B_BASE - AW'(i), {1'b1, (i == b_flag_at), bd[i]});
    end
    poke(A_BASE - AW'(n), 6'h2A);
    poke(B_BASE - AW'(n), 6'h19);
    poke(STRAY, 6'h15);
    // expected decimal sum
    c = 0; stop = (bad_sel != 0) ? bad_at : n;
    for (int i = 0; i < stop; i++) begin
      s = int'(ad[i]) + int'(bd[i]) + c;
      ed[i] = 4'(s % 10); c = s / 10;
    end
    exp_ovf = (bad_sel == 0) && (c != 0);
    lat = (bad_sel != 0) ? 4 * (bad_at + 1) - 1 : 4 * n;
    a_lo_addr = A_BASE; b_lo_addr = B_BASE; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R6", {name, " busy after start"}, 32'(busy), 32'd1);
    cnt = 0;
    while (cnt < 100) begin
      @(posedge clk); cnt++; #1;
      if (poke_mid) begin
        start = (cnt == 6); a_lo_addr = STRAY; b_lo_addr = STRAY;
      end
      if (done) break;
    end
    start = 1'b0;
    chk(poke_mid ? "R9" : "R6", {name, " done latency"}, 32'(cnt), 32'(lat));
    chk("R7", {name, " overflow"}, 32'(overflow), 32'(exp_ovf));
    chk("R8", {name, " digit_err"}, 32'(digit_err), 32'(bad_sel != 0));
    for (int i = 0; i < stop; i++)
      chk("R3", {name, " result cell"}, 32'(mem[A_BASE - AW'(i)]), 32'({a_sp[i], (i == n - 1), ed[i]}));
    if (bad_sel == 1)
      chk("R8", {name, " bad A cell untouched"}, 32'(mem[A_BASE - AW'(bad_at)]), 32'({a_sp[bad_at], (bad_at == n - 1), 4'hC}));
    if (bad_sel == 2)
      chk("R8", {name, " A cell at bad B untouched"}, 32'(mem[A_BASE - AW'(bad_at)]), 32'({a_sp[bad_at], (bad_at == n - 1), ad[bad_at]}));
    chk("R4", {name, " guard above A"}, 32'(mem[A_BASE - AW'(n)]), 32'h2A);
    chk("R9", {name, " stray cell"}, 32'(mem[STRAY]), 32'h15);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R6", {name, " done pulse ends"}, 32'(done), 32'd0);
    chk("R7", {name, " overflow held"}, 32'(overflow), 32'(exp_ovf));
    chk("R6", {name, " idle after"}, 32'(busy), 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "busy in reset", 32'(busy), 32'd0);
    chk("R10", "we in reset", 32'(mem_we), 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", "done after reset", 32'(done), 32'd0);
    chk("R10", "overflow after reset", 32'(overflow), 32'd0);
    chk("R10", "digit_err after reset", 32'(digit_err), 32'd0);
  endtask

  task automatic t_single;      run_case("single 3+4", 1, 32'h3, 32'h4, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_four;        run_case("0345+0002 R1", 4, 32'h0345, 32'h0002, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_ripple;      run_case("ripple R2", 4, 32'h0999, 32'h0001, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_overflow;    run_case("overflow", 4, 32'h9999, 32'h0001, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_clear_ovf;   run_case("clear ovf", 2, 32'h12, 32'h34, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_long;        run_case("eight digits", 8, 32'h58274619, 32'h67390588, -1, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_b_flag;      run_case("B marker ignored R4", 3, 32'h456, 32'h789, 0, 8'h00, 0, 0, 1'b0); endtask
  task automatic t_spare;       run_case("spare kept R5", 5, 32'h13579, 32'h24680, -1, 8'h15, 0, 0, 1'b0); endtask
  task automatic t_bad_a;       run_case("bad A digit", 4, 32'h1234, 32'h1111, -1, 8'h00, 1, 1, 1'b0); endtask
  task automatic t_bad_b;       run_case("bad B digit", 3, 32'h777, 32'h222, -1, 8'h00, 2, 0, 1'b0); endtask
  task automatic t_busy_start;  run_case("start while busy", 3, 32'h505, 32'h606, -1, 8'h00, 0, 0, 1'b1); endtask

  initial begin
    t_reset();
    t_single();
    t_four();
    t_ripple();
    t_overflow();
    t_clear_ovf();
    t_long();
    t_b_flag();
    t_spare();
    t_bad_a();
    t_bad_b();
    t_busy_start();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule